// File: doc/BRIEF.md
# Power-Fail Autostore Controller

This block decides when the working memory of a nonvolatile RAM must be saved into its shadow array because the supply is about to fail. It watches a digital supply-low flag, already produced by an analog comparator elsewhere. That flag is synchronised and debounced. When a software-armed enable latch is set and a low-supply event begins, the block raises a store request. The request stays up until the array copier reports completion.

The enable latch is set and cleared by decoded commands. It is cleared by the block reset and by a power-on-reset indication, so a part that was power-cycled can never save automatically until software arms it again. A status output behaves like an open-drain pin. It pulls low while the debounced supply-low flag is active and floats otherwise, so that several such pins can share one wired interrupt line. A global inhibit tells the rest of the device to stop all other work, either during an automatic store or while a separate deep-brownout flag is active.

All pins are plain level control and status signals. No data flows through the block, so it has no valid/ready handshake.

Top module: `pf_autostore`

## Requirements
- R1: After `rst_n` is released with all inputs low, `autostore_req`, `as_oe` and `inhibit_all` are 0.
- R2: `vcc_low` passes through a two-flop synchroniser and a filter that needs FILT_LEN consecutive equal synchronised samples before the filtered level changes. A pulse shorter than FILT_LEN cycles changes no output.
- R3: The enable latch is clear after reset and is cleared whenever `por_reset` is high. A low-supply event while the latch is clear raises no store request.
- R4: A one-cycle `cmd_enable_autostore` sets the latch and a one-cycle `cmd_reset_autostore` clears it. When both are high in the same cycle, the latch ends up clear.
- R5: `as_oe` is 1, and `as_n` is driven to 0, exactly while the filtered supply-low level is 1, whatever the state of the latch. With FILT_LEN=4, `as_oe` changes 6 cycles after `vcc_low` changes. While `as_oe` is 0, `as_n` is high impedance.
- R6: With the latch set, `autostore_req` rises one cycle after `as_oe` rises. It stays high until `store_done` is seen and is 0 in the cycle after `store_done`.
- R7: At most one store is issued for each low-supply event. Another store needs the filtered level to fall and then rise again.
- R8: `inhibit_all` is 1 while `autostore_req` is 1. It is also 1 while the synchronised `vcc_inhibit` is 1, which happens 2 cycles after the input changes.
- R9: Commands that arrive while `inhibit_all` is 1 leave the latch unchanged.
- R10: A store in progress finishes only on `store_done`, even if `vcc_low` is removed during the store.
- R11: The decision to store is taken when the filtered level first rises. Arming the latch later in the same event starts no store, but the next event will store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_low | input | 1 | Supply below store threshold (asynchronous) |
| por_reset | input | 1 | Power-on-reset indication, clears the latch (synchronous level) |
| cmd_enable_autostore | input | 1 | Decoded arm command, one-cycle pulse |
| cmd_reset_autostore | input | 1 | Decoded disarm command, one-cycle pulse |
| store_done | input | 1 | Array copy finished |
| vcc_inhibit | input | 1 | Supply below operating floor (asynchronous) |
| autostore_req | output | 1 | Request a whole-array store |
| as_n | output | 1 | Open-drain style status: 0 when active, high impedance otherwise |
| as_oe | output | 1 | Output enable of the status pull-down |
| inhibit_all | output | 1 | Halt all other device functions |

## Verification
The bench targets the places where a controller of this kind usually goes wrong. A glitch one sample short of the filter length must leave no trace. A design that counted total samples instead of consecutive ones would pull the status pin low here. A supply flag that stays low after the store completes must not start a second store; a design that re-triggers on the level would loop on stores. A reset command in the same cycle as an enable must win. A command sent during inhibit, and an arm that arrives in the middle of an event, must have no effect until the next event; a design that got these wrong would store when it is disarmed, or store late during brownout.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  // Store sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a low-supply event
    ST_STORE = 2'd1,  // store requested, waiting for completion
    ST_SPENT = 2'd2   // event already handled, waiting for supply recovery
  } store_st_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FILT_LEN    = 4;
endpackage

// File: rtl/pfa_sync.sv
module pfa_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfa_filter.sv
module pfa_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  output logic level
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic lvl_q;

  generate
    if (FILT_LEN <= 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= sample;
      end
    end else begin : g_count
      logic [CW-1:0] run_q;
      // A run of differing samples builds up; any agreeing sample restarts it
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= '0;
          lvl_q <= 1'b0;
        end else if (sample == lvl_q) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          run_q <= '0;
          lvl_q <= sample;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  assign level = lvl_q;

  // R2: the level only moves toward the value of the sample seen before
  p_filter_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(sample) == lvl_q));
endmodule

// File: rtl/pfa_arm_latch.sv
module pfa_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic por_clr,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic inhibit,
  output logic armed
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (por_clr)    en_q <= 1'b0;
    else if (!inhibit) begin
      if (clr_cmd)       en_q <= 1'b0;
      else if (set_cmd)  en_q <= 1'b1;
    end
  end

  assign armed = en_q;

  // R3: a power-on-reset indication always leaves the latch clear
  p_por_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    por_clr |=> !armed);
  // R4: clear command dominates a simultaneous set
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && clr_cmd && !inhibit) |=> !armed);
  // R9: while inhibited only power-on reset may touch the latch
  p_inhib_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !por_clr) |=> $stable(armed));
endmodule

// File: rtl/pfa_store_seq.sv
module pfa_store_seq
  import pfa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic low_lvl,
  input  logic armed,
  input  logic store_done,
  output logic req
);
  store_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (low_lvl)    st_d = armed ? ST_STORE : ST_SPENT;
      ST_STORE: if (store_done) st_d = low_lvl ? ST_SPENT : ST_IDLE;
      ST_SPENT: if (!low_lvl)   st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req = (st_q == ST_STORE);

  // R6, R10: a request persists until completion is reported
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !store_done) |=> req);
  // R11: a store begins only when the latch was set as the event began
  p_start_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(armed) && $past(low_lvl)));
  // R7: a completed store with supply still low never restarts at once
  p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && store_done && low_lvl) |=> (!req ##1 !req));
endmodule

// File: rtl/pf_autostore.sv
module pf_autostore
  import pfa_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = DEF_FILT_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low,
  input  logic por_reset,
  input  logic cmd_enable_autostore,
  input  logic cmd_reset_autostore,
  input  logic store_done,
  input  logic vcc_inhibit,
  output logic autostore_req,
  output logic as_n,
  output logic as_oe,
  output logic inhibit_all
);
  logic [1:0] raw_in, sync_out;
  logic       low_f, armed, req;

  assign raw_in = {vcc_inhibit, vcc_low};

  pfa_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  pfa_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .sample(sync_out[0]), .level(low_f)
  );

  pfa_arm_latch u_latch (
    .clk(clk), .rst_n(rst_n), .por_clr(por_reset),
    .set_cmd(cmd_enable_autostore), .clr_cmd(cmd_reset_autostore),
    .inhibit(inhibit_all), .armed(armed)
  );

  pfa_store_seq u_seq (
    .clk(clk), .rst_n(rst_n), .low_lvl(low_f), .armed(armed),
    .store_done(store_done), .req(req)
  );

  assign autostore_req = req;
  assign inhibit_all   = sync_out[1] | req;
  assign as_oe         = low_f;
  assign as_n          = as_oe ? 1'b0 : 1'bz;

  // R5: the status pin is pulled low whenever a request is outstanding
  // and the supply is still low
  p_status_with_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autostore_req) |-> as_oe);
endmodule

// File: tb/pf_autostore_test.sv
module pf_autostore_test;
  localparam int N = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, vcc_low, por_reset, cmd_en, cmd_rst, store_done, vcc_inhibit;
  logic autostore_req, as_n, as_oe, inhibit_all;

  pf_autostore #(.SYNC_STAGES(2), .FILT_LEN(N)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_low(vcc_low), .por_reset(por_reset),
    .cmd_enable_autostore(cmd_en), .cmd_reset_autostore(cmd_rst),
    .store_done(store_done), .vcc_inhibit(vcc_inhibit),
    .autostore_req(autostore_req), .as_n(as_n), .as_oe(as_oe),
    .inhibit_all(inhibit_all)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    req;
    int    oe;
    int    inh;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic expect_at(int dly, int req, int oe, int inh, string tag);
    exp_t e;
    e.at = cyc + dly; e.req = req; e.oe = oe; e.inh = inh; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cmp(string tag, string what, logic act, int expv);
    n_chk++;
    if (act !== expv[0]) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // monitor: pop every expectation that falls due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        if (sb[i].req >= 0) cmp(sb[i].tag, "autostore_req", autostore_req, sb[i].req);
        if (sb[i].oe  >= 0) cmp(sb[i].tag, "as_oe", as_oe, sb[i].oe);
        if (sb[i].oe  == 1) cmp(sb[i].tag, "as_n", as_n, 0);
        if (sb[i].inh >= 0) cmp(sb[i].tag, "inhibit_all", inhibit_all, sb[i].inh);
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_en();
    cmd_en = 1'b1; tick(1); cmd_en = 1'b0;
  endtask

  task automatic pulse_rst();
    cmd_rst = 1'b1; tick(1); cmd_rst = 1'b0;
  endtask

  task automatic pulse_done();
    store_done = 1'b1; tick(1); store_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; vcc_low = 1'b0; por_reset = 1'b0; cmd_en = 1'b0;
    cmd_rst = 1'b0; store_done = 1'b0; vcc_inhibit = 1'b0;
    tick(3);
    rst_n = 1'b1;
    expect_at(1, 0, 0, 0, "R1 reset");
    tick(4);

    // unarmed event: status only
    vcc_low = 1'b1;
    expect_at(5, 0, 0, 0, "R5 latency");
    expect_at(6, 0, 1, 0, "R5 assert");
    expect_at(8, 0, 1, 0, "R3 unarmed");
    tick(10);
    vcc_low = 1'b0;
    expect_at(5, 0, 1, 0, "R5 hold");
    expect_at(6, 0, 0, 0, "R5 release");
    tick(10);

    // glitch one sample short
    pulse_en();
    tick(2);
    vcc_low = 1'b1; tick(3); vcc_low = 1'b0;
    expect_at(3, 0, 0, 0, "R2 glitch");
    expect_at(6, 0, 0, 0, "R2 glitch");
    tick(12);

    // armed store, one per event, re-arm
    vcc_low = 1'b1;
    expect_at(6, 0, 1, 0, "R5 armed");
    expect_at(7, 1, 1, 1, "R6 start");
    tick(15);
    expect_at(1, 1, 1, 1, "R6 hold");
    tick(2);
    expect_at(1, 0, 1, 0, "R6 end");
    pulse_done();
    expect_at(10, 0, 1, 0, "R7 single");
    tick(12);
    vcc_low = 1'b0;
    expect_at(6, 0, 0, 0, "R5 release");
    tick(9);
    vcc_low = 1'b1;
    expect_at(7, 1, 1, 1, "R7 rearm");
    tick(10);
    vcc_low = 1'b0;
    expect_at(10, 1, 0, 1, "R10 continues");
    tick(12);
    expect_at(1, 0, 0, 0, "R10 end");
    pulse_done();
    tick(5);

    // power-on reset clears latch
    por_reset = 1'b1; tick(1); por_reset = 1'b0;
    tick(2);
    vcc_low = 1'b1;
    expect_at(6, 0, 1, 0, "R5");
    expect_at(8, 0, 1, 0, "R3 por");
    tick(12); vcc_low = 1'b0; tick(10);

    // both commands at once
    cmd_en = 1'b1; cmd_rst = 1'b1; tick(1); cmd_en = 1'b0; cmd_rst = 1'b0;
    tick(2);
    vcc_low = 1'b1;
    expect_at(8, 0, 1, 0, "R4 both");
    tick(12); vcc_low = 1'b0; tick(10);
    pulse_en(); pulse_rst(); tick(2);
    vcc_low = 1'b1;
    expect_at(8, 0, 1, 0, "R4 disarm");
    tick(12); vcc_low = 1'b0; tick(10);
    pulse_en(); tick(2);
    vcc_low = 1'b1;
    expect_at(7, 1, 1, 1, "R4 arm");
    tick(10);
    expect_at(1, 0, 1, 0, "R6 end");
    pulse_done();
    vcc_low = 1'b0; tick(10);

    // inhibit blocks commands
    pulse_rst(); tick(1);
    vcc_inhibit = 1'b1;
    expect_at(1, 0, 0, 0, "R8 sync");
    expect_at(2, 0, 0, 1, "R8 inhibit");
    tick(3);
    pulse_en();
    vcc_inhibit = 1'b0;
    expect_at(1, 0, 0, 1, "R8 still");
    expect_at(2, 0, 0, 0, "R8 drop");
    tick(5);
    vcc_low = 1'b1;
    expect_at(8, 0, 1, 0, "R9 ignored");
    tick(9);
    pulse_en();
    tick(5);
    expect_at(1, 0, 1, 0, "R11 no late start");
    tick(2);
    vcc_low = 1'b0; tick(10);
    vcc_low = 1'b1;
    expect_at(7, 1, 1, 1, "R11 next event");
    tick(10);
    pulse_done();
    vcc_low = 1'b0; tick(10);

    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule